// File: doc/BRIEF.md
# Configurable GPIO interrupt detector

This block watches a vector of sampled GPIO levels and raises per-pin interrupt causes. For each pin, software picks level or edge detection. In edge mode it picks either any transition or one polarity. Causes collect in a sticky status vector. Software clears status bits by writing ones. A single request line goes high when any enabled cause is pending.

The data and direction vectors come from the surrounding GPIO port. Both arrive already synchronised. A direction bit of 1 marks the pin as an output. A small word-addressed register bus carries all configuration and status access. Writes take effect at the clock edge that captures them. Reads return data one cycle after the request.

Top module: `gpio_irq_detect`

## Requirements
- R1: After a synchronous reset, every configuration and status register reads 0x00, `irq` is low and `rdata` is 0.
- R2: Word addresses are: 0 mode (1 = level, 0 = edge), 1 any-edge, 2 polarity, 3 enable mask, 4 raw status (read only), 5 masked status (read only), 6 clear (write only, reads 0). Address 7 reads 0. Registers 0 to 3 read back what was written. `rdata` is valid in the cycle after `rd_en` and is 0 in any cycle that follows no read.
- R3: For a pin in edge mode with its any-edge bit set, any change of its input level sets its raw status bit.
- R4: For a pin in edge mode with its any-edge bit clear, a change sets the raw bit only when the new level equals the pin's polarity bit (1 = rising, 0 = falling).
- R5: For a pin in level mode, the raw bit is set on every cycle in which the pin level equals its polarity bit (1 = high, 0 = low). The pin's direction does not gate this. A clear therefore has no lasting effect while the level persists.
- R6: Edges are not detected on pins whose direction bit is 1 (output).
- R7: Raw status bits stay set until software writes a 1 to the same bit position of the clear register. Writing 0 bits has no effect.
- R8: If a clear and a new event hit the same bit in the same cycle, the bit stays set.
- R9: The masked status equals raw status AND enable mask. `irq` is registered and goes high one cycle after any masked bit is set.
- R10: An edge is a difference between the current sample and the sample from the previous cycle. The previous-sample register resets to 0, and a level held steady produces no further edge events.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register word address |
| wdata | input | N | Write data |
| rdata | output | N | Registered read data |
| pin_data | input | N | Sampled pin levels |
| pin_dir | input | N | Direction per pin, 1 = output |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong previous-sample register shows up as a spurious or missing raw bit. It appears on the status read two cycles after the input change. A wrong clear or priority path leaves a bit set or cleared in the status read right after the clear write. Corrupted mode, polarity or mask state shows up in the readback. Through the masked status, the same corruption also reaches `irq` within one cycle of the raw change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned NUM_CFG = 4;

  typedef enum logic [ADDR_W-1:0] {
    RA_MODE    = 3'd0,
    RA_ANYEDGE = 3'd1,
    RA_POL     = 3'd2,
    RA_ENABLE  = 3'd3,
    RA_RAW     = 3'd4,
    RA_MASKED  = 3'd5,
    RA_CLEAR   = 3'd6
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      mode_q,
  output logic [N-1:0]      any_q,
  output logic [N-1:0]      pol_q,
  output logic [N-1:0]      mask_q,
  output logic [N-1:0]      clr_mask
);
  logic [N-1:0] cfg_q [NUM_CFG];

  // one plain register per configuration word
  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && addr == ADDR_W'(g)) begin
        cfg_q[g] <= wdata;
      end
    end
  end

  assign mode_q   = cfg_q[RA_MODE];
  assign any_q    = cfg_q[RA_ANYEDGE];
  assign pol_q    = cfg_q[RA_POL];
  assign mask_q   = cfg_q[RA_ENABLE];
  assign clr_mask = (wr_en && addr == RA_CLEAR) ? wdata : '0;
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin_data,
  input  logic [N-1:0] pin_dir,
  input  logic [N-1:0] mode,
  input  logic [N-1:0] any_edge,
  input  logic [N-1:0] pol,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] raw_q
);
  logic [N-1:0] prev_q;
  logic [N-1:0] set_v;

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic changed;
    logic match;
    assign changed  = (pin_data[i] ^ prev_q[i]) & ~pin_dir[i];
    assign match    = ~(pin_data[i] ^ pol[i]);
    assign set_v[i] = mode[i] ? match : (changed & (any_edge[i] | match));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      raw_q  <= '0;
    end else begin
      prev_q <= pin_data;
      // a new event takes priority over a simultaneous clear
      raw_q  <= (raw_q & ~clr_mask) | set_v;
    end
  end
endmodule

// File: rtl/gpio_irq_rdmux.sv
module gpio_irq_rdmux
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      mode,
  input  logic [N-1:0]      any_edge,
  input  logic [N-1:0]      pol,
  input  logic [N-1:0]      mask,
  input  logic [N-1:0]      raw,
  output logic [N-1:0]      rdata_q
);
  logic [N-1:0] sel;

  always_comb begin
    case (addr)
      RA_MODE:    sel = mode;
      RA_ANYEDGE: sel = any_edge;
      RA_POL:     sel = pol;
      RA_ENABLE:  sel = mask;
      RA_RAW:     sel = raw;
      RA_MASKED:  sel = raw & mask;
      default:    sel = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= sel;
    else            rdata_q <= '0;
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [N-1:0]      wdata,
  output logic [N-1:0]      rdata,
  input  logic [N-1:0]      pin_data,
  input  logic [N-1:0]      pin_dir,
  output logic              irq
);
  logic [N-1:0] mode_q, any_q, pol_q, mask_q, clr_mask, raw_q;

  gpio_irq_cfg #(.N(N)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .mode_q(mode_q), .any_q(any_q), .pol_q(pol_q), .mask_q(mask_q),
    .clr_mask(clr_mask)
  );

  gpio_irq_cause #(.N(N)) u_cause (
    .clk(clk), .rst(rst), .pin_data(pin_data), .pin_dir(pin_dir),
    .mode(mode_q), .any_edge(any_q), .pol(pol_q), .clr_mask(clr_mask),
    .raw_q(raw_q)
  );

  gpio_irq_rdmux #(.N(N)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr),
    .mode(mode_q), .any_edge(any_q), .pol(pol_q), .mask(mask_q),
    .raw(raw_q), .rdata_q(rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(raw_q & mask_q);
  end
endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk #(
  parameter int unsigned N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         wr_en,
  input logic         rd_en,
  input logic [2:0]   addr,
  input logic [N-1:0] rdata,
  input logic [N-1:0] pin_data,
  input logic [N-1:0] pin_dir,
  input logic [N-1:0] raw_q,
  input logic [N-1:0] mode_q,
  input logic [N-1:0] pol_q,
  input logic [N-1:0] mask_q,
  input logic         irq
);
  p_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == 3'd6) |=> ((raw_q & $past(raw_q)) == $past(raw_q)));

  p_level_set_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(mode_q) & ~($past(pin_data) ^ $past(pol_q))) & ~raw_q) == '0));

  p_out_pin_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & ~$past(raw_q) & ~$past(mode_q) & $past(pin_dir)) == '0));

  p_irq_follow_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(raw_q) & $past(mask_q))));

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0));
endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.N(N)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .pin_data(pin_data), .pin_dir(pin_dir), .raw_q(raw_q),
  .mode_q(mode_q), .pol_q(pol_q), .mask_q(mask_q), .irq(irq)
);

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // fields: {dir, mode, any, pol, mask, before, after}
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hA5},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'hF0, 8'hFF, 8'h0F},
    {8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h3C},
    {8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h3C},
    {8'h00, 8'h00, 8'h00, 8'hAA, 8'h0F, 8'h00, 8'hFF},
    {8'hF0, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h00, 8'hFF},
    {8'h00, 8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h0F, 8'h3C},
    {8'hFF, 8'h0F, 8'h00, 8'h00, 8'h01, 8'h05, 8'h50},
    {8'h00, 8'h00, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h11},
    {8'h00, 8'h0F, 8'h30, 8'hC3, 8'h3C, 8'h55, 8'h9A}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, pin_data = '0, pin_dir = '0;
  logic [7:0] rdata;
  logic irq;
  int n_cmp = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_irq_detect #(.N(8)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_data(pin_data), .pin_dir(pin_dir),
    .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // expected raw status from the requirements
  function automatic logic [7:0] model(input logic [55:0] v);
    logic [7:0] dir, md, an, pl, bf, af, r;
    {dir, md, an, pl} = v[55:24];
    bf = v[15:8];
    af = v[7:0];
    r = '0;
    for (int i = 0; i < 8; i++) begin
      if (md[i]) r[i] = (bf[i] == pl[i]) || (af[i] == pl[i]);
      else r[i] = !dir[i] && (bf[i] != af[i]) && (an[i] || af[i] == pl[i]);
    end
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, e;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset values, R2 unmapped reads
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 rdata", rdata, 8'h00);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check("R1 R2 reset read", d, 8'h00);
    end
    // R2 readback and clear register read
    wr(3'd0, 8'h5A); wr(3'd1, 8'hC3); wr(3'd2, 8'h96); wr(3'd3, 8'h0F);
    rd(3'd0, d); check("R2 mode", d, 8'h5A);
    rd(3'd1, d); check("R2 anyedge", d, 8'hC3);
    rd(3'd2, d); check("R2 pol", d, 8'h96);
    rd(3'd3, d); check("R2 mask", d, 8'h0F);
    rd(3'd6, d); check("R2 clear reads 0", d, 8'h00);
    idle(1);
    check("R2 rdata idle", rdata, 8'h00);

    // table walk: R3 R4 R5 R6 R9
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      pin_dir = VEC[k][55:48];
      pin_data = VEC[k][15:8];
      wr(3'd0, VEC[k][47:40]);
      wr(3'd1, VEC[k][39:32]);
      wr(3'd2, VEC[k][31:24]);
      wr(3'd3, VEC[k][23:16]);
      idle(2);
      wr(3'd6, 8'hFF);
      pin_data = VEC[k][7:0];
      idle(2);
      e = model(VEC[k]);
      rd(3'd4, d); check("R3 R4 R5 R6 raw", d, e);
      rd(3'd5, d); check("R9 masked", d, e & VEC[k][23:16]);
      check("R9 irq", {7'd0, irq}, {7'd0, |(e & VEC[k][23:16])});
    end

    // R7 sticky and write-one-to-clear
    wr(3'd0, 8'h00); wr(3'd1, 8'hFF); wr(3'd3, 8'h00);
    pin_dir = 8'h00; pin_data = 8'h00;
    idle(2);
    wr(3'd6, 8'hFF);
    pin_data = 8'h01;
    idle(4);
    rd(3'd4, d); check("R7 sticky", d, 8'h01);
    wr(3'd6, 8'h02);
    rd(3'd4, d); check("R7 zero bit no effect", d, 8'h01);
    wr(3'd6, 8'h01);
    rd(3'd4, d); check("R7 cleared", d, 8'h00);
    // R10 steady level creates no new events
    idle(5);
    rd(3'd4, d); check("R10 no event when steady", d, 8'h00);

    // R8 event wins over simultaneous clear on bit 1
    @(negedge clk);
    wr_en = 1'b1; addr = 3'd6; wdata = 8'h02; pin_data = 8'h03;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
    rd(3'd4, d); check("R8 event wins", d, 8'h02);
    wr(3'd6, 8'hFF);

    // R5 level re-asserts after clear
    wr(3'd0, 8'h01); wr(3'd2, 8'h01);
    idle(2);
    wr(3'd6, 8'h01);
    rd(3'd4, d); check("R5 level reasserts", d, 8'h01);

    // R9 irq with mask enabled
    wr(3'd3, 8'h01);
    idle(2);
    check("R9 irq high", {7'd0, irq}, 8'h01);
    wr(3'd3, 8'h00);
    idle(2);
    check("R9 irq low when masked", {7'd0, irq}, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule